// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one 32-pin general-purpose I/O bank with a small synchronous register port. Each pin is either a plain output or an interrupt source. Control registers are reached through three aliases: a direct write that replaces the whole word, a write-one-to-set alias and a write-one-to-clear alias. Software can therefore flip single pin bits without a read-modify-write sequence. Two per-pin pattern bits serve two purposes: while a pin is not selected for interrupts, the low pattern bit is the level driven on its output; once it is selected, the two pattern bits choose the trigger.

Pin inputs pass through a two-stage synchronizer, and one further register holds the previous synchronized value for edge detection. Each pin keeps a pending flag. Software acknowledges a pin by writing a one to the flag's clear alias. A per-pin mask gates the flags into a single combined interrupt line for a parent controller. The trigger logic sees one edge at a time. Software gets both-edge behaviour by re-programming the edge after each acknowledge.

Address decode uses bits [7:4] to pick the register and bits [3:0] to pick the access kind: 0 is direct, 4 is set, 8 is clear. Register indices: 0 is input level (read only), 1 is interrupt select, 2 is mask, 3 is high pattern bit, 4 is low pattern bit, 5 is pending flag. Consecutive banks are spaced 0x100 apart in the system map, so the bank sees an 8-bit offset.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, select, both pattern registers and the flags read 0, the mask reads 0xFFFFFFFF, `pin_out` is 0 and `irq_out` is 0.
- R2: For select, mask and both pattern registers, a write at offset +0x0 replaces the value. A write at +0x4 sets every bit written as 1. A write at +0x8 clears every bit written as 1. Bits written as 0 through +0x4 or +0x8 keep their value.
- R3: A read of offset 0x00 returns the pin inputs after two synchronizing clocks.
- R4: `pin_out[i]` equals low pattern bit i when select bit i is 0, and is 0 when select bit i is 1.
- R5: With select=1 and pattern {high,low}=11, a 0-to-1 transition of the synchronized input sets the pin's flag.
- R6: With select=1 and pattern 10, a 1-to-0 transition sets the flag, and a rising transition does not.
- R7: With pattern 01 the flag is set while the input is high; with pattern 00 it is set while the input is low. After an acknowledge, a persisting level sets the flag again on the next clock.
- R8: Flags are cleared only by a write to offset 0x58 with the pin's bit set to 1. Writes to 0x50 and 0x54 change no flag. A clear in the same cycle as a trigger wins.
- R9: `irq_out` is 1 exactly when some pin has its flag at 1 and its mask bit at 0.
- R10: A pin whose select bit is 0 never gets a new flag.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Offsets that are not a register base (for example 0x24 or 0x60) read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Offset within the bank |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output level for each pin |
| irq_out | output | 1 | Combined interrupt to the parent controller |

## Verification
Some properties are checked on every cycle. A clear-alias write must leave the written flag bits at zero, and set or clear aliases on select and mask must take effect. No flag may appear on an unselected pin. Every rise or fall of the combined interrupt must coincide with a change in flags or mask. Only the bench scenarios can show the rest: that each trigger encoding catches the right transitions, that level flags re-assert after an acknowledge, that edges can be alternated by software, and that synchronized levels read back through the port.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_ADDR_W = 8;

    // register index carried in offset bits [7:4]
    typedef enum logic [3:0] {
        IDX_LEVEL  = 4'h0,
        IDX_SEL    = 4'h1,
        IDX_MASK   = 4'h2,
        IDX_PAT_HI = 4'h3,
        IDX_PAT_LO = 4'h4,
        IDX_FLAG   = 4'h5
    } reg_idx_e;

    // access kind carried in offset bits [3:0]
    typedef enum logic [3:0] {
        ACC_DIRECT = 4'h0,
        ACC_SET    = 4'h4,
        ACC_CLEAR  = 4'h8
    } access_e;

    // {pattern high, pattern low} in interrupt mode
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_idx,
    input  logic [3:0]       wr_acc,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] sel_q,
    output logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] pat_hi_q,
    output logic [NPINS-1:0] pat_lo_q
);

    // merge one write into a current value according to the alias used
    function automatic logic [NPINS-1:0] merge_wr(
        input logic [NPINS-1:0] cur,
        input logic [3:0]       acc,
        input logic [NPINS-1:0] d
    );
        logic [NPINS-1:0] res;
        case (acc)
            ACC_DIRECT: res = d;
            ACC_SET:    res = cur | d;
            ACC_CLEAR:  res = cur & ~d;
            default:    res = cur;
        endcase
        return res;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            mask_q   <= '1;
            pat_hi_q <= '0;
            pat_lo_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_SEL:    sel_q    <= merge_wr(sel_q,    wr_acc, wr_data);
                IDX_MASK:   mask_q   <= merge_wr(mask_q,   wr_acc, wr_data);
                IDX_PAT_HI: pat_hi_q <= merge_wr(pat_hi_q, wr_acc, wr_data);
                IDX_PAT_LO: pat_lo_q <= merge_wr(pat_lo_q, wr_acc, wr_data);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] level_o,
    output logic [NPINS-1:0] prev_o
);

    localparam int LAST = STAGES - 1;

    logic [NPINS-1:0] stage_q [STAGES];
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[LAST];
        end
    end

    assign level_o = stage_q[LAST];
    assign prev_o  = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sel,
    input  logic [NPINS-1:0] pat_hi,
    input  logic [NPINS-1:0] pat_lo,
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] prev,
    input  logic [NPINS-1:0] ack,
    output logic [NPINS-1:0] flag_q
);

    function automatic logic trig_hit(input trig_e t, input logic now, input logic was);
        logic h;
        unique case (t)
            TRIG_RISE: h = now & ~was;
            TRIG_FALL: h = ~now & was;
            TRIG_HIGH: h = now;
            TRIG_LOW:  h = ~now;
        endcase
        return h;
    endfunction

    logic [NPINS-1:0] hit_v;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign hit_v[i] = sel[i] & trig_hit(trig_e'({pat_hi[i], pat_lo[i]}), level[i], prev[i]);
    end

    // an acknowledge wins over a trigger in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q | hit_v) & ~ack;
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]      bus_wdata,
    output logic [NPINS-1:0]      bus_rdata,
    input  logic [NPINS-1:0]      pin_in,
    output logic [NPINS-1:0]      pin_out,
    output logic                  irq_out
);

    logic [3:0]       reg_idx;
    logic [3:0]       reg_acc;
    logic [NPINS-1:0] sel_q, mask_q, pat_hi_q, pat_lo_q, flag_q;
    logic [NPINS-1:0] lvl_s, prev_s, ack_v, rd_mux, rdata_q;

    assign reg_idx = bus_addr[7:4];
    assign reg_acc = bus_addr[3:0];

    gpio_ctrl_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_idx   (reg_idx),
        .wr_acc   (reg_acc),
        .wr_data  (bus_wdata),
        .sel_q    (sel_q),
        .mask_q   (mask_q),
        .pat_hi_q (pat_hi_q),
        .pat_lo_q (pat_lo_q)
    );

    gpio_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .level_o (lvl_s),
        .prev_o  (prev_s)
    );

    // flags are acknowledged only through the clear alias
    assign ack_v = (bus_wr && reg_idx == IDX_FLAG && reg_acc == ACC_CLEAR) ? bus_wdata : '0;

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel_q),
        .pat_hi (pat_hi_q),
        .pat_lo (pat_lo_q),
        .level  (lvl_s),
        .prev   (prev_s),
        .ack    (ack_v),
        .flag_q (flag_q)
    );

    always_comb begin
        rd_mux = '0;
        if (reg_acc == ACC_DIRECT) begin
            case (reg_idx)
                IDX_LEVEL:  rd_mux = lvl_s;
                IDX_SEL:    rd_mux = sel_q;
                IDX_MASK:   rd_mux = mask_q;
                IDX_PAT_HI: rd_mux = pat_hi_q;
                IDX_PAT_LO: rd_mux = pat_lo_q;
                IDX_FLAG:   rd_mux = flag_q;
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = pat_lo_q & ~sel_q;
    assign irq_out   = |(flag_q & ~mask_q);

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] sel_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] flag_q,
    input logic             irq_out
);

    AST_FLAG_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h58) |=> ((flag_q & $past(bus_wdata)) == '0)); // R8

    AST_SEL_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h14) |=> ((sel_q & $past(bus_wdata)) == $past(bus_wdata))); // R2

    AST_MASK_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h28) |=> ((mask_q & $past(bus_wdata)) == '0)); // R2

    AST_NO_FLAG_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(sel_q)) == '0)); // R10

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> (((flag_q & ~$past(flag_q)) != '0) || (($past(mask_q) & ~mask_q) != '0))); // R9

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> ((($past(flag_q) & ~flag_q) != '0) || ((mask_q & ~$past(mask_q)) != '0))); // R9

endmodule

bind gpio_irq_bank gpio_irq_checker #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sel_q     (sel_q),
    .mask_q    (mask_q),
    .flag_q    (flag_q),
    .irq_out   (irq_out)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_out;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    gpio_irq_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected flags after settling on a, clearing, then moving to b
    function automatic logic [31:0] expect_flags(input logic [31:0] s, h, l, a, b);
        return s & ((h & l & ~a & b) | (h & ~l & a & ~b) |
                    (~h & l & (a | b)) | (~h & ~l & (~a | ~b)));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd91577));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, irq_out}, 32'd0);
        check("R1 pin_out", pin_out, 32'd0);
        reg_rd(8'h10, d); check("R1 sel", d, 32'd0);
        reg_rd(8'h20, d); check("R1 mask", d, 32'hFFFF_FFFF);
        reg_rd(8'h30, d); check("R1 pat_hi", d, 32'd0);
        reg_rd(8'h40, d); check("R1 pat_lo", d, 32'd0);
        reg_rd(8'h50, d); check("R1 flag", d, 32'd0);

        // R11 non-base offsets read as zero
        reg_rd(8'h24, d); check("R11 alias read", d, 32'd0);
        reg_rd(8'h60, d); check("R11 unused read", d, 32'd0);

        // R2 aliases
        reg_wr(8'h44, 32'h0000_00A5); reg_rd(8'h40, d); check("R2 set", d, 32'h0000_00A5);
        reg_wr(8'h48, 32'h0000_000F); reg_rd(8'h40, d); check("R2 clear", d, 32'h0000_00A0);
        reg_wr(8'h44, 32'h0);         reg_rd(8'h40, d); check("R2 zero bits", d, 32'h0000_00A0);
        reg_wr(8'h40, 32'h1234_5678); reg_rd(8'h40, d); check("R2 direct", d, 32'h1234_5678);

        // R4 output gating by select
        check("R4 output", pin_out, 32'h1234_5678);
        reg_wr(8'h14, 32'h0000_00FF); check("R4 selected", pin_out, 32'h1234_5600);
        reg_wr(8'h18, 32'h0000_00FF); check("R4 released", pin_out, 32'h1234_5678);

        // R3 synchronized level read
        pin_in = $urandom; idle(4);
        reg_rd(8'h00, d); check("R3 level", d, pin_in);

        // R5/R6 alternating edges on pin 0
        pin_in = '0; idle(4);
        reg_wr(8'h40, 32'h0); reg_wr(8'h30, 32'h1); reg_wr(8'h44, 32'h1);
        reg_wr(8'h58, 32'hFFFF_FFFF); reg_wr(8'h10, 32'h1); reg_wr(8'h28, 32'h1);
        check("R5 quiet", {31'd0, irq_out}, 32'd0);
        pin_in[0] = 1'b1; idle(4);
        check("R5 rise irq", {31'd0, irq_out}, 32'd1);
        reg_rd(8'h50, d); check("R5 rise flag", d, 32'h1);
        reg_wr(8'h48, 32'h1); reg_wr(8'h58, 32'h1); idle(2);
        check("R6 no rise", {31'd0, irq_out}, 32'd0);
        pin_in[0] = 1'b0; idle(4);
        reg_rd(8'h50, d); check("R6 fall flag", d, 32'h1);

        // R8 only the clear alias acknowledges
        reg_wr(8'h50, 32'h0); reg_wr(8'h54, 32'h2);
        reg_rd(8'h50, d); check("R8 ignored writes", d, 32'h1);
        reg_wr(8'h58, 32'h1);
        reg_rd(8'h50, d); check("R8 ack", d, 32'h0);

        // R7 level high re-asserts after acknowledge
        reg_wr(8'h44, 32'h1); reg_wr(8'h38, 32'h1);
        reg_wr(8'h58, 32'h1);
        pin_in[0] = 1'b1; idle(4);
        check("R7 level irq", {31'd0, irq_out}, 32'd1);
        reg_wr(8'h58, 32'h1);
        check("R7 cleared", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        check("R7 reassert", {31'd0, irq_out}, 32'd1);
        pin_in[0] = 1'b0; idle(4);
        reg_wr(8'h58, 32'h1); idle(2);
        check("R7 level gone", {31'd0, irq_out}, 32'd0);

        // R10 unselected pins never flag
        reg_wr(8'h10, 32'h0); reg_wr(8'h58, 32'hFFFF_FFFF); reg_wr(8'h20, 32'h0);
        pin_in = $urandom; idle(4); pin_in = ~pin_in; idle(4);
        reg_rd(8'h50, d); check("R10 no flags", d, 32'h0);
        check("R9 no irq", {31'd0, irq_out}, 32'd0);

        // random trigger mixes, R5 R6 R7 R9
        for (int it = 0; it < 16; it++) begin
            logic [31:0] s, h, l, m, a, b, e;
            s = $urandom; h = $urandom; l = $urandom; m = $urandom;
            a = $urandom; b = $urandom;
            reg_wr(8'h10, 32'h0);
            pin_in = a; idle(4);
            reg_wr(8'h30, h); reg_wr(8'h40, l); reg_wr(8'h20, m);
            reg_wr(8'h10, s); reg_wr(8'h58, 32'hFFFF_FFFF);
            idle(1);
            pin_in = b; idle(4);
            e = expect_flags(s, h, l, a, b);
            reg_rd(8'h50, d); check("R5 R6 R7 random flags", d, e);
            check("R9 random irq", {31'd0, irq_out}, {31'd0, |(e & ~m)});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule